// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor's byte-wide load/store port and a memory port that moves whole 4-byte lines. It keeps copies of recently used lines. Two lines can live at each set index, and a single recency bit per set picks which one to replace. Stores normally stay in the cache and mark the line modified. A modified line goes back to memory only when it is replaced or when software asks for a flush.

Three run-time controls change how the cache behaves. A write-through switch sends every store hit to memory as a full-line write. A bypass switch sends each access straight to memory as a single transaction. Two one-cycle commands drop all lines: one discards them, and the other first pushes every modified line out. Each command signals completion with a one-cycle done pulse.

The processor issues one request at a time while `cpu_ready` is high. It then waits for the `cpu_ack` pulse, which can take several memory round trips.

Top module: `c2w_cache`

## Requirements
- R1: A 24-bit byte address splits into byte select `addr[1:0]`, set index `addr[SET_BITS+1:2]` and tag (all higher bits; 9 bits when SET_BITS is 13). Byte k of a line is line bits `8k+7:8k`. A read returns the addressed byte of the line.
- R2: Each set holds two lines, and both are compared with the tag in one lookup. Two blocks with the same set index stay resident together and both hit.
- R3: On a miss with both lines valid, the line not referenced most recently in that set is replaced. The most recently referenced line stays resident.
- R4: An invalid line is always filled before any valid line in its set is replaced.
- R5: A store hit in normal mode changes only the cache and marks the line modified. No memory transaction takes place.
- R6: A replaced line is written to memory (one full-line write to its own block address) before the refill read, and only if it is modified. A clean victim costs exactly one block read.
- R7: A store miss reads the block, merges the byte and leaves the line modified. A later flush writes the merged line back.
- R8: With `wr_thru` high, a store hit also issues one full-line write of the updated line. The write does not mark the line modified.
- R9: With `cache_off` high, every access is one memory transaction and no line is looked up or filled. A read is a block read with `mem_be`=4'hF. A store sets `mem_be` to the one-hot lane `1<<addr[1:0]` and puts the byte in all four lanes.
- R10: A `cmd_inv` pulse in the idle state drops every line with no memory write. `flush_done` pulses for one cycle afterwards.
- R11: A `cmd_flush` pulse writes each valid modified line to memory, then drops every line and pulses `flush_done`. If both commands arrive together, `cmd_flush` wins.
- R12: `cpu_ready` is high only in the idle state. `cpu_ack` is a one-cycle pulse, and `cpu_rdata` holds the read byte while it is high. `mem_req` and `mem_addr` hold steady until `mem_ack`.
- R13: After reset all lines are invalid, `cpu_ready` is high, and `mem_req`, `cpu_ack` and `flush_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Idle and able to accept a request or command |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Load byte, valid with cpu_ack |
| cache_off | input | 1 | Bypass: all accesses go to memory |
| wr_thru | input | 1 | Store hits also write memory |
| cmd_inv | input | 1 | Drop all lines without write-back |
| cmd_flush | input | 1 | Write back modified lines, then drop all |
| flush_done | output | 1 | One-cycle pulse when a command completes |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Block-aligned address |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Write line |
| mem_rdata | input | 32 | Read line, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion from memory |

## Verification
Some rules are checked by assertions on every cycle. At most one line can match a tag. A victim is chosen among invalid lines whenever one exists. The eviction and flush write states only ever carry modified lines. Bypass mode never fills the arrays. A clear leaves no valid line. The memory and processor handshakes are held stable, with one-cycle pulses. Other behaviour shows only over a sequence of accesses, so the bench's scenarios cover it. The bench counts block reads and writes per access to tell hits from clean and dirty misses. It checks that data written back survives eviction, and that the recency bit keeps the right block. It also checks that bypassed stores leave nothing allocated, and that invalidate loses a modified byte while flush preserves it.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
  localparam int ADDR_W = 24;
  localparam int OFS_W  = 2;
  localparam int LINE_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_EVICT, ST_FILL, ST_THRU, ST_DIRECT, ST_SCAN, ST_PUSH
  } c2w_state_e;

  function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] line,
                                           input logic [OFS_W-1:0] sel);
    return line[sel*8 +: 8];
  endfunction

  function automatic logic [LINE_W-1:0] put_byte(input logic [LINE_W-1:0] line,
                                                 input logic [OFS_W-1:0] sel,
                                                 input logic [7:0] b);
    logic [LINE_W-1:0] r;
    r = line;
    r[sel*8 +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/c2w_way.sv
module c2w_way
  import c2w_pkg::*;
#(
  parameter int SET_BITS = 5,
  parameter int TAG_W    = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] rd_idx,
  output logic [TAG_W-1:0]    rd_tag,
  output logic                rd_valid,
  output logic                rd_dirty,
  output logic [LINE_W-1:0]   rd_data,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic                wr_dirty,
  input  logic [LINE_W-1:0]   wr_data,
  input  logic                clr_all
);
  localparam int SETS = 1 << SET_BITS;

  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (clr_all) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_q == '0) && (dirty_q == '0));
endmodule

// File: rtl/c2w_ctrl.sv
module c2w_ctrl
  import c2w_pkg::*;
#(
  parameter int SET_BITS = 5,
  parameter int TAG_W    = 17
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [7:0]                   cpu_wdata,
  output logic                         cpu_ready,
  output logic                         cpu_ack,
  output logic [7:0]                   cpu_rdata,
  input  logic                         cache_off,
  input  logic                         wr_thru,
  input  logic                         cmd_inv,
  input  logic                         cmd_flush,
  output logic                         flush_done,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [3:0]                   mem_be,
  output logic [LINE_W-1:0]            mem_wdata,
  input  logic [LINE_W-1:0]            mem_rdata,
  input  logic                         mem_ack,
  output logic [SET_BITS-1:0]          look_idx,
  input  logic [1:0][TAG_W-1:0]        way_tag,
  input  logic [1:0]                   way_valid,
  input  logic [1:0]                   way_dirty,
  input  logic [1:0][LINE_W-1:0]       way_data,
  output logic [1:0]                   way_wr_en,
  output logic [TAG_W-1:0]             way_wr_tag,
  output logic                         way_wr_dirty,
  output logic [LINE_W-1:0]            way_wr_data,
  output logic                         way_clr
);
  localparam int SETS = 1 << SET_BITS;
  localparam int TAG_LO = SET_BITS + OFS_W;

  c2w_state_e state;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [7:0]        wd_q;
  logic              sel_q;
  logic [SET_BITS:0] fl_q;
  logic [SETS-1:0]   use_q;

  logic [SET_BITS-1:0] req_set;
  logic [TAG_W-1:0]    req_tag;
  logic [OFS_W-1:0]    req_ofs;
  assign req_set = addr_q[TAG_LO-1:OFS_W];
  assign req_tag = addr_q[ADDR_W-1:TAG_LO];
  assign req_ofs = addr_q[OFS_W-1:0];

  logic [SET_BITS-1:0] scan_set;
  logic scan_way, scan_last, scan_dirty;
  assign scan_set   = fl_q[SET_BITS:1];
  assign scan_way   = fl_q[0];
  assign scan_last  = &fl_q;
  assign scan_dirty = way_valid[scan_way] && way_dirty[scan_way];

  assign look_idx = (state == ST_SCAN || state == ST_PUSH) ? scan_set : req_set;

  // lookup events, brought out for the checks
  logic [1:0] hit_vec;
  logic hit, hit_way, vict_way, vict_dirty, ev_look, ev_miss;
  assign hit_vec[0] = way_valid[0] && (way_tag[0] == req_tag);
  assign hit_vec[1] = way_valid[1] && (way_tag[1] == req_tag);
  assign hit        = |hit_vec;
  assign hit_way    = hit_vec[1];
  assign ev_look    = (state == ST_LOOK) && !cache_off;
  assign ev_miss    = ev_look && !hit;
  always_comb begin
    if (!way_valid[0])      vict_way = 1'b0;
    else if (!way_valid[1]) vict_way = 1'b1;
    else                    vict_way = ~use_q[req_set];
  end
  assign vict_dirty = way_valid[vict_way] && way_dirty[vict_way];

  assign cpu_ready = (state == ST_IDLE);

  assign way_clr = (state == ST_IDLE && !cmd_flush && cmd_inv)
                || (state == ST_SCAN && !scan_dirty && scan_last)
                || (state == ST_PUSH && mem_ack && scan_last);

  always_comb begin
    way_wr_en    = '0;
    way_wr_tag   = req_tag;
    way_wr_dirty = 1'b0;
    way_wr_data  = mem_rdata;
    if (ev_look && hit && we_q) begin
      way_wr_en[hit_way] = 1'b1;
      way_wr_dirty       = way_dirty[hit_way] | ~wr_thru;
      way_wr_data        = put_byte(way_data[hit_way], req_ofs, wd_q);
    end else if (state == ST_FILL && mem_ack) begin
      way_wr_en[sel_q] = 1'b1;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    mem_be    = 4'hF;
    mem_wdata = way_data[sel_q];
    case (state)
      ST_EVICT: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {way_tag[sel_q], req_set, {OFS_W{1'b0}}};
      end
      ST_FILL: mem_req = 1'b1;
      ST_THRU: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      ST_DIRECT: begin
        mem_req   = 1'b1;
        mem_we    = we_q;
        mem_wdata = {4{wd_q}};
        if (we_q) mem_be = 4'b0001 << req_ofs;
      end
      ST_PUSH: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {way_tag[scan_way], scan_set, {OFS_W{1'b0}}};
        mem_wdata = way_data[scan_way];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      we_q       <= 1'b0;
      wd_q       <= '0;
      sel_q      <= 1'b0;
      fl_q       <= '0;
      use_q      <= '0;
      cpu_ack    <= 1'b0;
      cpu_rdata  <= '0;
      flush_done <= 1'b0;
    end else begin
      cpu_ack    <= 1'b0;
      flush_done <= way_clr;
      case (state)
        ST_IDLE: begin
          if (cmd_flush) begin
            fl_q  <= '0;
            state <= ST_SCAN;
          end else if (!cmd_inv && cpu_req) begin
            addr_q <= cpu_addr;
            we_q   <= cpu_we;
            wd_q   <= cpu_wdata;
            state  <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (cache_off) begin
            state <= ST_DIRECT;
          end else if (hit) begin
            use_q[req_set] <= hit_way;
            sel_q          <= hit_way;
            cpu_rdata      <= pick_byte(way_data[hit_way], req_ofs);
            if (we_q && wr_thru) state <= ST_THRU;
            else begin
              cpu_ack <= 1'b1;
              state   <= ST_IDLE;
            end
          end else begin
            sel_q <= vict_way;
            state <= vict_dirty ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: if (mem_ack) state <= ST_FILL;
        ST_FILL:  if (mem_ack) state <= ST_LOOK;
        ST_THRU: if (mem_ack) begin
          cpu_ack <= 1'b1;
          state   <= ST_IDLE;
        end
        ST_DIRECT: if (mem_ack) begin
          cpu_ack   <= 1'b1;
          cpu_rdata <= pick_byte(mem_rdata, req_ofs);
          state     <= ST_IDLE;
        end
        ST_SCAN: begin
          if (scan_dirty)     state <= ST_PUSH;
          else if (scan_last) state <= ST_IDLE;
          else                fl_q  <= fl_q + 1'b1;
        end
        ST_PUSH: if (mem_ack) begin
          if (scan_last) state <= ST_IDLE;
          else begin
            fl_q  <= fl_q + 1'b1;
            state <= ST_SCAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_look |-> $countones(hit_vec) <= 1);
  assert_invalid_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss && !(&way_valid)) |-> !way_valid[vict_way]);
  assert_evict_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EVICT) |-> (way_valid[sel_q] && way_dirty[sel_q]));
  assert_bypass_no_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIRECT) |-> (way_wr_en == 2'b00));
  assert_push_dirty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH) |-> (way_valid[scan_way] && way_dirty[scan_way]));
  assert_done_follows_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> $past(way_clr));
  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
  assert_busy_on_mem_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);
endmodule

// File: rtl/c2w_cache.sv
module c2w_cache
  import c2w_pkg::*;
#(
  parameter int SET_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [7:0]          cpu_wdata,
  output logic                cpu_ready,
  output logic                cpu_ack,
  output logic [7:0]          cpu_rdata,
  input  logic                cache_off,
  input  logic                wr_thru,
  input  logic                cmd_inv,
  input  logic                cmd_flush,
  output logic                flush_done,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [3:0]          mem_be,
  output logic [LINE_W-1:0]   mem_wdata,
  input  logic [LINE_W-1:0]   mem_rdata,
  input  logic                mem_ack
);
  localparam int TAG_W = ADDR_W - SET_BITS - OFS_W;

  logic [SET_BITS-1:0]     look_idx;
  logic [1:0][TAG_W-1:0]   way_tag;
  logic [1:0]              way_valid, way_dirty, way_wr_en;
  logic [1:0][LINE_W-1:0]  way_data;
  logic [TAG_W-1:0]        way_wr_tag;
  logic                    way_wr_dirty, way_clr;
  logic [LINE_W-1:0]       way_wr_data;

  for (genvar w = 0; w < 2; w++) begin : g_way
    c2w_way #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) way_i (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(look_idx), .rd_tag(way_tag[w]), .rd_valid(way_valid[w]),
      .rd_dirty(way_dirty[w]), .rd_data(way_data[w]),
      .wr_en(way_wr_en[w]), .wr_idx(look_idx), .wr_tag(way_wr_tag),
      .wr_dirty(way_wr_dirty), .wr_data(way_wr_data), .clr_all(way_clr)
    );
  end

  c2w_ctrl #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .cache_off(cache_off), .wr_thru(wr_thru), .cmd_inv(cmd_inv), .cmd_flush(cmd_flush),
    .flush_done(flush_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .look_idx(look_idx), .way_tag(way_tag), .way_valid(way_valid), .way_dirty(way_dirty),
    .way_data(way_data), .way_wr_en(way_wr_en), .way_wr_tag(way_wr_tag),
    .way_wr_dirty(way_wr_dirty), .way_wr_data(way_wr_data), .way_clr(way_clr)
  );
endmodule

// File: tb/c2w_cache_tb_top.sv
module c2w_cache_tb_top;
  localparam int CLK_T = 10;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_ready, cpu_ack;
  logic [7:0] cpu_rdata;
  logic cache_off = 1'b0, wr_thru = 1'b0, cmd_inv = 1'b0, cmd_flush = 1'b0;
  logic flush_done;
  logic mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  c2w_cache #(.SET_BITS(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .cache_off(cache_off), .wr_thru(wr_thru), .cmd_inv(cmd_inv), .cmd_flush(cmd_flush),
    .flush_done(flush_done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // memory model: 1024 words, one-cycle ack, counts transactions
  logic [31:0] mem_w [1024];
  logic [7:0]  shw [4096];
  int rd_cnt = 0, wr_cnt = 0;
  int total = 0, bad = 0;

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem_w[mem_addr[11:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem_w[mem_addr[11:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end else mem_ack <= 1'b0;
  end

  function automatic logic [7:0] mbyte(input int a);
    return mem_w[a >> 2][(a & 3)*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [23:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    int t;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    t = 0;
    while (!cpu_ack && t < 300) begin @(negedge clk); t++; end
    chk(t < 300, "R12", "ack timeout", t, 0);
    rd = cpu_rdata;
    if (we) shw[a[11:0]] = d;
  endtask

  task automatic command(input bit flush);
    int t;
    @(negedge clk);
    if (flush) cmd_flush = 1'b1; else cmd_inv = 1'b1;
    @(negedge clk);
    cmd_flush = 1'b0; cmd_inv = 1'b0;
    t = 0;
    while (!flush_done && t < 500) begin @(negedge clk); t++; end
    chk(t < 500, flush ? "R11" : "R10", "done timeout", t, 0);
    @(negedge clk);
    chk(flush_done == 1'b0, flush ? "R11" : "R10", "done pulse width", flush_done, 0);
  endtask

  // set = a[6:2], tag = a[23:7] with SET_BITS=5
  localparam logic        V_WE   [NV] = '{0,0,1,0,0,0,0,0,0,1,0,0,0,0};
  localparam logic [23:0] V_ADDR [NV] = '{24'h08C,24'h08D,24'h08E,24'h10C,24'h08C,24'h18C,
                                          24'h20C,24'h08E,24'h20D,24'h29C,24'h29C,24'h29D,
                                          24'h19C,24'h29C};
  localparam logic [7:0]  V_DAT  [NV] = '{8'h00,8'h00,8'h5A,8'h00,8'h00,8'h00,8'h00,
                                          8'h00,8'h00,8'h33,8'h00,8'h00,8'h00,8'h00};
  localparam int          V_RD   [NV] = '{1,0,0,1,0,1,1,1,0,1,0,0,1,0};
  localparam int          V_WR   [NV] = '{0,0,0,0,0,0,1,0,0,0,0,0,0,0};

  function automatic string vreq(input int i);
    case (i)
      0, 11:       return "R1";
      1, 3, 4:     return "R2";
      2:           return "R5";
      5, 6:        return "R6";
      7, 8:        return "R3";
      9, 10:       return "R7";
      default:     return "R4";
    endcase
  endfunction

  bit finished = 1'b0;

  initial begin
    #(CLK_T * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int r0, w0;
    logic [31:0] word;
    for (int i = 0; i < 1024; i++)
      mem_w[i] = {i[7:0] ^ 8'hA5, ~i[7:0], i[9:2] + 8'h11, i[7:0]};
    for (int i = 0; i < 4096; i++) shw[i] = mbyte(i);

    repeat (3) @(negedge clk);
    // R13 reset state
    chk(cpu_ready == 1'b1, "R13", "ready in reset", cpu_ready, 1);
    chk(mem_req == 1'b0 && cpu_ack == 1'b0 && flush_done == 1'b0, "R13", "quiet outputs",
        {mem_req, cpu_ack, flush_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready == 1'b1 && mem_req == 1'b0, "R13", "idle after reset", {cpu_ready, mem_req}, 2);

    // vector table
    for (int i = 0; i < NV; i++) begin
      r0 = rd_cnt; w0 = wr_cnt;
      access(V_WE[i], V_ADDR[i], V_DAT[i], rd);
      if (!V_WE[i]) chk(rd == shw[V_ADDR[i][11:0]], vreq(i), "read byte", rd, shw[V_ADDR[i][11:0]]);
      chk(rd_cnt - r0 == V_RD[i], vreq(i), "block reads", rd_cnt - r0, V_RD[i]);
      chk(wr_cnt - w0 == V_WR[i], vreq(i), "block writes", wr_cnt - w0, V_WR[i]);
    end

    // R8 write-through hit
    wr_thru = 1'b1;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, 24'h08F, 8'h77, rd);
    chk(rd_cnt - r0 == 0 && wr_cnt - w0 == 1, "R8", "thru traffic", (rd_cnt - r0) * 16 + wr_cnt - w0, 1);
    chk(mbyte(24'h08F) == 8'h77, "R8", "memory updated", mbyte(24'h08F), 8'h77);
    chk(mbyte(24'h08E) == 8'h5A, "R8", "full line written", mbyte(24'h08E), 8'h5A);
    wr_thru = 1'b0;

    // R9 bypass
    cache_off = 1'b1;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b0, 24'h08D, 8'h00, rd);
    chk(rd_cnt - r0 == 1 && wr_cnt - w0 == 0, "R9", "bypass read traffic", rd_cnt - r0, 1);
    chk(rd == shw[12'h08D], "R9", "bypass read byte", rd, shw[12'h08D]);
    word = mem_w[24'h30C >> 2];
    word[7:0] = 8'h11;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, 24'h30C, 8'h11, rd);
    chk(rd_cnt - r0 == 0 && wr_cnt - w0 == 1, "R9", "bypass write traffic", wr_cnt - w0, 1);
    chk(mem_w[24'h30C >> 2] == word, "R9", "single lane written", mem_w[24'h30C >> 2], word);
    cache_off = 1'b0;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b0, 24'h30C, 8'h00, rd);
    chk(rd_cnt - r0 == 1 && wr_cnt - w0 == 0, "R9", "no line allocated", rd_cnt - r0, 1);
    chk(rd == 8'h11, "R9", "bypassed byte visible", rd, 8'h11);

    // R11 write back and invalidate: only set 7 line (0x29C) is modified
    w0 = wr_cnt;
    command(1'b1);
    chk(wr_cnt - w0 == 1, "R11", "dirty lines written", wr_cnt - w0, 1);
    chk(mbyte(24'h29C) == 8'h33, "R11", "flushed byte", mbyte(24'h29C), 8'h33);
    r0 = rd_cnt;
    access(1'b0, 24'h29C, 8'h00, rd);
    chk(rd_cnt - r0 == 1, "R11", "lines dropped", rd_cnt - r0, 1);
    chk(rd == 8'h33, "R11", "data kept", rd, 8'h33);

    // R10 invalidate discards a modified byte
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, 24'h29D, 8'h44, rd);
    chk(rd_cnt - r0 == 0 && wr_cnt - w0 == 0, "R5", "store hit local", wr_cnt - w0, 0);
    w0 = wr_cnt;
    command(1'b0);
    chk(wr_cnt - w0 == 0, "R10", "no write-back", wr_cnt - w0, 0);
    shw[12'h29D] = mbyte(24'h29D);
    r0 = rd_cnt;
    access(1'b0, 24'h29D, 8'h00, rd);
    chk(rd_cnt - r0 == 1, "R10", "line dropped", rd_cnt - r0, 1);
    chk(rd == shw[12'h29D] && rd != 8'h44, "R10", "modified byte lost", rd, shw[12'h29D]);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule